// File: doc/BRIEF.md
# Multi-Threshold Pulse Edge Assembler

A single analog pulse is fed to four comparators, each set to a different and increasing voltage threshold. Channel A has the lowest threshold and channel D the highest. A time-to-digital encoder in front of this block turns every comparator transition into a timestamp. Each timestamp carries a flag that says whether it was a crossing on the rising side of the pulse (leading) or on the falling side (trailing). The block collects these stamps into one event record. This samples the shape of the pulse in the voltage domain rather than timing a single edge.

An event opens on the first leading edge seen on any threshold. It stays open for a programmable number of clock cycles, then closes. For every threshold the record carries:
- the leading and trailing times, both made relative to the most recent stamp of a separate reference channel;
- the width at that level, used as a charge estimate;
- a validity bit.

The record also flags widths that would be negative, and whether the leading times rise with the threshold as a well-formed pulse requires. The record is presented with a valid/ready handshake. Hit rates are low, so one record buffer is enough: edges that arrive while a record waits to be taken are dropped.

Top module: `mtp_edge_assembler`

## Requirements
- R1: After reset `ev_valid` is 0, and the stored reference time is 0.
- R2: While no event is open, a leading edge (`hit_vld[i]` with `hit_lead[i]`=1) on any channel opens one. Trailing edges (`hit_lead[i]`=0) alone never open an event.
- R3: Cycle 0 is the cycle that carries the opening edge. Edges presented in cycles 0 to `win_len` are taken into the event, and edges in later cycles are not. `ev_valid` is 1 from cycle `win_len`+1 onward. `win_len` is at least 1.
- R4: Per channel only the first leading edge and the first trailing edge count. A trailing edge counts only if that channel already recorded its leading edge in an earlier cycle of the same event.
- R5: Bit i of `ev_mask` is 1 only when channel i recorded both edges. If it is 0, the width field for that channel is 0. A missing leading or trailing time is reported as 0. Channel i (A=0 … D=3) occupies bits [16i+15:16i] of every wide bus, with the default 16-bit time width.
- R6: For a channel with both edges, the width is trailing minus leading as unsigned raw times. If the trailing time is less than the leading time, bit i of `ev_neg` is set and the width is 0. `ev_neg` is 0 for channels whose mask bit is 0.
- R7: Each reported time is the raw time minus the reference snapshot, modulo 2^16. The snapshot is the latest `ref_time` presented at or before cycle `win_len` of the event. References presented after that cycle do not affect the record.
- R8: While `ev_valid`=1 and `ev_ready`=0, all record fields stay unchanged, and new edges are ignored. After a cycle with `ev_valid` and `ev_ready` both 1, `ev_valid` is 0. A leading edge presented in that accepting cycle does not open an event.
- R9: `ev_mono` is 1 exactly when, for every neighbouring pair (A,B), (B,C), (C,D) where both channels recorded a leading edge, the higher threshold's raw leading time is not less than the lower one's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | 8 | Event window length in cycles after the opening cycle |
| hit_vld | input | 4 | Per-channel timestamp strobe |
| hit_lead | input | 4 | Per-channel polarity: 1 leading, 0 trailing |
| hit_time | input | 64 | Per-channel raw timestamps, channel i at [16i+15:16i] |
| ref_vld | input | 1 | Reference timestamp strobe |
| ref_time | input | 16 | Reference timestamp |
| ev_valid | output | 1 | Event record available |
| ev_ready | input | 1 | Consumer accepts the record |
| ev_lead | output | 64 | Relative leading times per channel |
| ev_trail | output | 64 | Relative trailing times per channel |
| ev_width | output | 64 | Per-channel width (trailing minus leading) |
| ev_mask | output | 4 | Channel recorded both edges |
| ev_neg | output | 4 | Channel width was negative |
| ev_mono | output | 1 | Leading times non-decreasing from A to D |

## Verification
The hardest cases to reach from the ports are edges that fall exactly on the closing cycle or just past it, together with a reference stamp arriving in that same cycle. Such cases decide both membership in the event and which reference is used. The bench sweeps every leading-edge schedule over cycles 0 to 2 on all four channels, with trailing offsets that cross the window boundary, for window lengths 1 to 3. It places a reference stamp on the closing cycle and another one cycle later. The same sweep produces reversed leading orders, negative widths, and trailing edges without leading edges.

// File: rtl/mtp_edge_assembler.sv
`timescale 1ns/1ps
module mtp_edge_assembler #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   win_len,
  input  logic [3:0]      hit_vld,
  input  logic [3:0]      hit_lead,
  input  logic [4*TW-1:0] hit_time,
  input  logic            ref_vld,
  input  logic [TW-1:0]   ref_time,
  output logic            ev_valid,
  input  logic            ev_ready,
  output logic [4*TW-1:0] ev_lead,
  output logic [4*TW-1:0] ev_trail,
  output logic [4*TW-1:0] ev_width,
  output logic [3:0]      ev_mask,
  output logic [3:0]      ev_neg,
  output logic            ev_mono
);
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_HOLD = 2'd2;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [3:0]    seen_l, seen_t;
  logic [TW-1:0] lead_r [4];
  logic [TW-1:0] trail_r [4];
  logic [TW-1:0] ref_last, ref_snap;
  logic [3:0]    lead_in;

  assign lead_in  = hit_vld & hit_lead;
  assign ev_valid = (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      seen_l   <= '0;
      seen_t   <= '0;
      ref_last <= '0;
      ref_snap <= '0;
      for (int i = 0; i < 4; i++) begin
        lead_r[i]  <= '0;
        trail_r[i] <= '0;
      end
    end else begin
      if (ref_vld) ref_last <= ref_time;
      case (st)
        S_IDLE: if (|lead_in) begin
          st     <= S_OPEN;
          cnt    <= 1;
          seen_l <= lead_in;
          seen_t <= '0;
          for (int i = 0; i < 4; i++)
            if (lead_in[i]) lead_r[i] <= hit_time[i*TW +: TW];
        end
        S_OPEN: begin
          for (int i = 0; i < 4; i++) begin
            if (hit_vld[i] && hit_lead[i] && !seen_l[i]) begin
              seen_l[i] <= 1'b1;
              lead_r[i] <= hit_time[i*TW +: TW];
            end else if (hit_vld[i] && !hit_lead[i] && seen_l[i] && !seen_t[i]) begin
              seen_t[i]  <= 1'b1;
              trail_r[i] <= hit_time[i*TW +: TW];
            end
          end
          if (cnt >= win_len) begin
            st       <= S_HOLD;
            ref_snap <= ref_vld ? ref_time : ref_last;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: if (ev_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [2:0] order_bad;

  for (genvar g = 0; g < 4; g++) begin : g_ch
    logic both, neg;
    assign both = seen_l[g] & seen_t[g];
    assign neg  = both & (trail_r[g] < lead_r[g]);
    assign ev_mask[g] = both;
    assign ev_neg[g]  = neg;
    assign ev_width[g*TW +: TW] = (both && !neg) ? trail_r[g] - lead_r[g] : '0;
    assign ev_lead[g*TW +: TW]  = seen_l[g] ? lead_r[g] - ref_snap : '0;
    assign ev_trail[g*TW +: TW] = seen_t[g] ? trail_r[g] - ref_snap : '0;
    if (g > 0) begin : g_ord
      assign order_bad[g-1] = seen_l[g] & seen_l[g-1] & (lead_r[g] < lead_r[g-1]);
    end
  end

  assign ev_mono = ~|order_bad;
endmodule

// File: rtl/mtp_edge_assembler_chk.sv
`timescale 1ns/1ps
module mtp_edge_assembler_chk #(
  parameter int TW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic [4*TW-1:0] ev_lead,
  input logic [4*TW-1:0] ev_trail,
  input logic [4*TW-1:0] ev_width,
  input logic [3:0]      ev_mask,
  input logic [3:0]      ev_neg
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_lead) && $stable(ev_trail)
      && $stable(ev_width) && $stable(ev_mask) && $stable(ev_neg));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_valid);

  p_neg_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_neg & ~ev_mask) == 4'b0);

  for (genvar g = 0; g < 4; g++) begin : g_a
    p_width_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !ev_mask[g] |-> ev_width[g*TW +: TW] == '0);
    p_neg_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_neg[g] |-> ev_width[g*TW +: TW] == '0);
  end
endmodule

bind mtp_edge_assembler mtp_edge_assembler_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_lead(ev_lead), .ev_trail(ev_trail), .ev_width(ev_width),
  .ev_mask(ev_mask), .ev_neg(ev_neg)
);

// File: tb/sim_mtp_edge_assembler.sv
`timescale 1ns/1ps
module sim_mtp_edge_assembler;
  localparam int TW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] win_len = 8'd1;
  logic [3:0] hit_vld = '0, hit_lead = '0;
  logic [4*TW-1:0] hit_time = '0;
  logic ref_vld = 1'b0;
  logic [TW-1:0] ref_time = '0;
  logic ev_valid, ev_ready = 1'b0, ev_mono;
  logic [4*TW-1:0] ev_lead, ev_trail, ev_width;
  logic [3:0] ev_mask, ev_neg;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mtp_edge_assembler #(.TW(TW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .win_len(win_len), .hit_vld(hit_vld),
    .hit_lead(hit_lead), .hit_time(hit_time), .ref_vld(ref_vld),
    .ref_time(ref_time), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_lead(ev_lead), .ev_trail(ev_trail), .ev_width(ev_width),
    .ev_mask(ev_mask), .ev_neg(ev_neg), .ev_mono(ev_mono)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    hit_vld = '0; hit_lead = '0; hit_time = '0; ref_vld = 1'b0;
  endtask

  task automatic put(input int ch, input bit lead, input logic [15:0] t);
    hit_vld[ch] = 1'b1; hit_lead[ch] = lead; hit_time[ch*TW +: TW] = t;
  endtask

  initial begin
    logic [4*TW-1:0] s_lead, s_trail, s_width;
    logic [3:0] s_mask;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", ev_valid, 0);

    // R2: trailing edges alone never open an event
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); clr();
      for (int i = 0; i < 4; i++) put(i, 0, 16'(50 + i));
    end
    ok = 1;
    for (int c = 0; c < 8; c++) begin @(negedge clk); clr(); if (ev_valid) ok = 0; end
    chk("R2 no open on trailing", ok, 1);

    // R4: duplicates and trailing-before-leading, win_len 4
    win_len = 4;
    @(negedge clk); clr(); put(0, 1, 10); ref_vld = 1; ref_time = 5;
    @(negedge clk); clr(); put(0, 1, 20); put(1, 0, 30);
    @(negedge clk); clr(); put(1, 1, 40); put(0, 0, 50);
    @(negedge clk); clr(); put(0, 0, 60); put(1, 0, 70);
    for (int c = 0; c < 3; c++) begin @(negedge clk); clr(); end
    chk("R2 open by leading", ev_valid, 1);
    chk("R4 mask", ev_mask, 4'b0011);
    chk("R4 lead", ev_lead, {16'd0, 16'd0, 16'd35, 16'd5});
    chk("R4 trail", ev_trail, {16'd0, 16'd0, 16'd65, 16'd45});
    chk("R4 width", ev_width, {16'd0, 16'd0, 16'd30, 16'd40});
    chk("R9 mono ordered", ev_mono, 1);

    // R8: hold while not ready, edges ignored
    s_lead = ev_lead; s_trail = ev_trail; s_width = ev_width; s_mask = ev_mask;
    ok = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (!ev_valid || ev_lead !== s_lead || ev_trail !== s_trail ||
          ev_width !== s_width || ev_mask !== s_mask) ok = 0;
      clr(); put(2, 1, 777); put(0, 0, 3); ref_vld = 1; ref_time = 999;
    end
    @(negedge clk);
    if (!ev_valid || ev_lead !== s_lead || ev_mask !== s_mask) ok = 0;
    chk("R8 held record", ok, 1);
    clr(); ev_ready = 1; put(3, 1, 123);
    @(negedge clk); clr(); ev_ready = 0;
    chk("R8 drop after accept", ev_valid, 0);
    ok = 1;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (ev_valid) ok = 0; end
    chk("R8 accept-cycle lead ignored", ok, 1);

    // Sweep: R3, R5, R6, R7, R9
    for (int w = 1; w <= 3; w++) begin
      for (int p = 0; p < 256; p++) begin
        int lc[4], tc[4];
        logic [15:0] lt[4], tt[4], rA, rB, rX, rexp;
        logic [63:0] e_lead, e_trail, e_width;
        logic [3:0] e_mask, e_neg, al, at;
        bit e_mono, any0, vok;
        any0 = 0;
        for (int i = 0; i < 4; i++) begin
          lc[i] = (p >> (2*i)) & 3;
          if (lc[i] == 0) any0 = 1;
          lt[i] = 16'(1000 + ((i*37 + p*11) % 64));
          tt[i] = ((i + p) % 3 == 0) ? lt[i] - 16'd5 : lt[i] + 16'(9 + i);
          tc[i] = (lc[i] == 3) ? ((i + p) % 4) : lc[i] + 1 + ((i + p) % (w + 1));
        end
        if (!any0) continue;
        rA = 16'(1040 + p % 29); rB = 16'(3 + p); rX = 16'hBEEF;
        win_len = 8'(w);
        vok = 1;
        for (int c = 0; c < 8; c++) begin
          @(negedge clk);
          if (c > 0 && ev_valid !== (c - 1 >= w)) vok = 0;
          clr();
          for (int i = 0; i < 4; i++) begin
            if (lc[i] != 3 && lc[i] == c) put(i, 1, lt[i]);
            if (tc[i] == c) put(i, 0, tt[i]);
          end
          if (c == 0) begin ref_vld = 1; ref_time = rA; end
          if (c == w && p[0]) begin ref_vld = 1; ref_time = rB; end
          if (c == w + 1) begin ref_vld = 1; ref_time = rX; end
        end
        @(negedge clk); clr();
        if (ev_valid !== 1'b1) vok = 0;
        chk("R3 window timing", vok, 1);
        rexp = p[0] ? rB : rA;
        e_mono = 1;
        for (int i = 0; i < 4; i++) begin
          al[i] = (lc[i] != 3) && (lc[i] <= w);
          at[i] = al[i] && (tc[i] <= w) && (tc[i] > lc[i]);
          e_mask[i] = al[i] & at[i];
          e_neg[i] = e_mask[i] && (tt[i] < lt[i]);
          e_width[i*16 +: 16] = (e_mask[i] && !e_neg[i]) ? tt[i] - lt[i] : 16'd0;
          e_lead[i*16 +: 16]  = al[i] ? lt[i] - rexp : 16'd0;
          e_trail[i*16 +: 16] = at[i] ? tt[i] - rexp : 16'd0;
          if (i > 0 && al[i] && al[i-1] && lt[i] < lt[i-1]) e_mono = 0;
        end
        chk("R5 mask", ev_mask, e_mask);
        chk("R7 lead relative", ev_lead, e_lead);
        chk("R7 trail relative", ev_trail, e_trail);
        chk("R6 width", ev_width, e_width);
        chk("R6 neg flag", ev_neg, e_neg);
        chk("R9 mono", ev_mono, e_mono);
        ev_ready = 1;
        @(negedge clk); ev_ready = 0;
        chk("R8 release", ev_valid, 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule